// File: doc/BRIEF.md
# Columnsort Sequencing Engine

This block sorts a small matrix of keys kept in on-chip storage. The matrix has R = S*S rows and S columns, so it holds N = S*S*S keys. The keys are treated as laid out column by column. A single iterative column sorter does all of the comparison work. A controller runs seven fixed passes over the matrix:

- four column-sort passes;
- a reshape that reads the matrix column by column and refills it row by row;
- the inverse of that reshape;
- a row pass made of two odd-even compare-exchange steps between neighbouring columns.

After the last pass, the keys read back in column-major order form a non-decreasing sequence.

A client fills the matrix through a one-key-per-cycle load port while the engine is idle, then pulses start. It waits for the done flag and reads the result through a random-access read port. The controller has six states:

- ST_IDLE accepts loads and start.
- ST_COL_LOAD copies one column into the sorter.
- ST_COL_WAIT waits for the sorter and writes the column back in place.
- ST_PERMUTE copies one key per cycle into the other half of a double buffer.
- ST_ROW_FIX treats one row per cycle.
- ST_DONE holds the result and accepts loads and start.

The transitions are:

- ST_IDLE goes to ST_COL_LOAD on start.
- ST_COL_LOAD goes to ST_COL_WAIT.
- ST_COL_WAIT goes back to ST_COL_LOAD while columns remain.
- At the end of a pass, ST_COL_WAIT, ST_PERMUTE or ST_ROW_FIX moves to the state that runs the next pass. After pass 7 it moves to ST_DONE.
- ST_DONE goes to ST_COL_LOAD on start, or to ST_IDLE on a load.

Top module: `colsort_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy and done are both low.
- R2: When the engine is not busy, the k-th key accepted on the load port is stored at column-major index k, which is column k div R and row k mod R. It can be read on rd_key by driving rd_addr = k before start is given. The load index wraps to 0 after N keys.
- R3: A start pulse in ST_IDLE or ST_DONE begins pass 1, and busy is high in the next cycle. A start pulse while busy has no effect.
- R4: Load strobes while busy, or in the same cycle as an accepted start, are dropped and do not change the sorted result.
- R5: When pass 7 ends, done is high and busy is low. Reading rd_addr = 0..N-1 then gives a non-decreasing sequence.
- R6: The result is exactly the multiset of the loaded keys, with every duplicate kept.
- R7: Passes 1, 3 and 7 sort every column ascending. Pass 5 sorts columns with an even index ascending and columns with an odd index descending. Each column leaves the sorter fully ordered in its direction.
- R8: Pass 2 moves the key at column-major index k to index (k mod S)*R + k div S, and pass 4 applies the inverse move. Both write into the opposite half of the double buffer, which then becomes the active half.
- R9: Passes run strictly in the order 1 to 7. Pass 6 works on each row in two steps. The first step compare-exchanges columns (2i, 2i+1). The second step compare-exchanges columns (2i-1, 2i). In both steps the smaller key goes to the lower column index.
- R10: A load while done is high clears done, returns the engine to ST_IDLE, and stores that key at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load strobe, one key per cycle |
| load_key | input | KEY_W | Key to be loaded |
| start | input | 1 | Pulse that begins the seven passes |
| busy | output | 1 | High while passes are running |
| done | output | 1 | High when the sorted result is held |
| rd_addr | input | $clog2(N) | Column-major read index |
| rd_key | output | KEY_W | Key at rd_addr, or 0 if rd_addr is out of range |

## Verification
The assertions assume that start and load_valid are synchronous strobes that settle well before each rising edge. They also assume that rd_addr only selects what rd_key shows and never affects the passes. The bench drives every input on the falling edge. It keeps start to single-cycle pulses and issues load strobes while busy only to show that they are dropped. It loads exactly N keys before each run, so the input multiset it predicts the result from is fully known.

// File: rtl/colsort_pkg.sv
package colsort_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COL_LOAD,
        ST_COL_WAIT,
        ST_PERMUTE,
        ST_ROW_FIX,
        ST_DONE
    } cs_state_e;

    localparam int PASS_W = 4;

    function automatic cs_state_e after_pass(input logic [PASS_W-1:0] p);
        cs_state_e s;
        unique case (p)
            4'd1, 4'd3:       s = ST_PERMUTE;
            4'd2, 4'd4, 4'd6: s = ST_COL_LOAD;
            4'd5:             s = ST_ROW_FIX;
            default:          s = ST_DONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/colsort_sorter.sv
module colsort_sorter #(
    parameter int KEY_W = 8,
    parameter int R     = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      desc,
    input  logic [R-1:0][KEY_W-1:0]   din,
    output logic [R-1:0][KEY_W-1:0]   dout,
    output logic                      running
);
    localparam int CNT_W = $clog2(R);

    logic [R-1:0][KEY_W-1:0] vec_q, vec_d;
    logic                    desc_q, run_q;
    logic [CNT_W-1:0]        cnt_q;

    always_comb begin
        vec_d = vec_q;
        for (int i = 0; i < R - 1; i++) begin
            if ((i % 2) == int'(cnt_q[0])) begin
                if (desc_q ? (vec_q[i] < vec_q[i+1]) : (vec_q[i] > vec_q[i+1])) begin
                    vec_d[i]   = vec_q[i+1];
                    vec_d[i+1] = vec_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            desc_q <= 1'b0;
            run_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (load) begin
            vec_q  <= din;
            desc_q <= desc;
            run_q  <= 1'b1;
            cnt_q  <= '0;
        end else if (run_q) begin
            vec_q <= vec_d;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(R - 1)) run_q <= 1'b0;
        end
    end

    assign dout    = vec_q;
    assign running = run_q;

    function automatic logic is_ordered(input logic [R-1:0][KEY_W-1:0] v, input logic d);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < R - 1; i++) begin
            if (d ? (v[i] < v[i+1]) : (v[i] > v[i+1])) ok = 1'b0;
        end
        return ok;
    endfunction

    // each finished column is ordered in its requested direction
    assert_column_ordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> is_ordered(vec_q, desc_q));

endmodule

// File: rtl/colsort_rowfix.sv
module colsort_rowfix #(
    parameter int KEY_W = 8,
    parameter int S     = 3
) (
    input  logic [S-1:0][KEY_W-1:0] row_in,
    output logic [S-1:0][KEY_W-1:0] row_out
);
    logic [S-1:0][KEY_W-1:0] mid;

    always_comb begin
        mid = row_in;
        for (int c = 0; c < S - 1; c += 2) begin
            if (row_in[c] > row_in[c+1]) begin
                mid[c]   = row_in[c+1];
                mid[c+1] = row_in[c];
            end
        end
        row_out = mid;
        for (int c = 1; c < S - 1; c += 2) begin
            if (mid[c] > mid[c+1]) begin
                row_out[c]   = mid[c+1];
                row_out[c+1] = mid[c];
            end
        end
    end

endmodule

// File: rtl/colsort_perm_map.sv
module colsort_perm_map #(
    parameter int S  = 3,
    parameter int AW = 5
) (
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int R = S * S;

    always_comb begin
        int v;
        v    = int'(idx);
        addr = AW'((v % S) * R + v / S);
    end

endmodule

// File: rtl/colsort_engine.sv
module colsort_engine
    import colsort_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int S     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_valid,
    input  logic [KEY_W-1:0]          load_key,
    input  logic                      start,
    output logic                      busy,
    output logic                      done,
    input  logic [$clog2(S*S*S)-1:0]  rd_addr,
    output logic [KEY_W-1:0]          rd_key
);
    localparam int R  = S * S;
    localparam int N  = R * S;
    localparam int AW = $clog2(N);
    localparam int CW = $clog2(S);
    localparam int RW = $clog2(R);

    cs_state_e          state_q, state_d;
    logic               pass_end;
    logic [PASS_W-1:0]  pass_q;
    logic [CW-1:0]      col_q;
    logic [RW-1:0]      row_q;
    logic [AW-1:0]      k_q, ld_ptr_q, map_addr;
    logic               act_q, nact;
    logic               open_q, take_start, take_load;

    logic [KEY_W-1:0]        mem [2][N];
    logic [R-1:0][KEY_W-1:0] col_vec, srt_out;
    logic [S-1:0][KEY_W-1:0] row_vec, row_out;
    logic                    srt_run, srt_load, srt_desc;

    assign nact       = ~act_q;
    assign open_q     = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign take_start = open_q && start;
    assign take_load  = open_q && load_valid && !start;

    always_comb begin
        for (int i = 0; i < R; i++) col_vec[i] = mem[act_q][AW'(int'(col_q) * R + i)];
        for (int c = 0; c < S; c++) row_vec[c] = mem[act_q][AW'(c * R + int'(row_q))];
    end

    assign srt_load = (state_q == ST_COL_LOAD);
    assign srt_desc = (pass_q == 4'd5) && col_q[0];

    colsort_sorter #(.KEY_W(KEY_W), .R(R)) u_sorter (
        .clk(clk), .rst_n(rst_n), .load(srt_load), .desc(srt_desc),
        .din(col_vec), .dout(srt_out), .running(srt_run)
    );

    colsort_rowfix #(.KEY_W(KEY_W), .S(S)) u_rowfix (
        .row_in(row_vec), .row_out(row_out)
    );

    colsort_perm_map #(.S(S), .AW(AW)) u_map (
        .idx(k_q), .addr(map_addr)
    );

    // next-state logic
    always_comb begin
        state_d  = state_q;
        pass_end = 1'b0;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_COL_LOAD;
            ST_COL_LOAD: state_d = ST_COL_WAIT;
            ST_COL_WAIT: begin
                if (!srt_run) begin
                    if (col_q == CW'(S - 1)) pass_end = 1'b1;
                    else                     state_d  = ST_COL_LOAD;
                end
            end
            ST_PERMUTE:  if (k_q == AW'(N - 1)) pass_end = 1'b1;
            ST_ROW_FIX:  if (row_q == RW'(R - 1)) pass_end = 1'b1;
            ST_DONE: begin
                if (start)           state_d = ST_COL_LOAD;
                else if (load_valid) state_d = ST_IDLE;
            end
            default:     state_d = ST_IDLE;
        endcase
        if (pass_end) state_d = after_pass(pass_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pass, index and buffer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q   <= '0;
            col_q    <= '0;
            row_q    <= '0;
            k_q      <= '0;
            ld_ptr_q <= '0;
            act_q    <= 1'b0;
        end else begin
            if (take_start) begin
                pass_q   <= 4'd1;
                col_q    <= '0;
                ld_ptr_q <= '0;
            end else if (take_load) begin
                ld_ptr_q <= (ld_ptr_q == AW'(N - 1)) ? '0 : ld_ptr_q + 1'b1;
            end
            if (state_q == ST_COL_WAIT && !srt_run && !pass_end) col_q <= col_q + 1'b1;
            if (state_q == ST_PERMUTE) begin
                k_q <= k_q + 1'b1;
                if (pass_end) act_q <= nact;
            end
            if (state_q == ST_ROW_FIX) row_q <= row_q + 1'b1;
            if (pass_end) begin
                pass_q <= pass_q + 1'b1;
                col_q  <= '0;
                row_q  <= '0;
                k_q    <= '0;
            end
        end
    end

    // key storage
    always_ff @(posedge clk) begin
        if (take_load) mem[act_q][ld_ptr_q] <= load_key;
        unique case (state_q)
            ST_COL_WAIT: if (!srt_run)
                for (int i = 0; i < R; i++) mem[act_q][AW'(int'(col_q) * R + i)] <= srt_out[i];
            ST_PERMUTE:
                if (pass_q == 4'd2) mem[nact][map_addr] <= mem[act_q][k_q];
                else                mem[nact][k_q]      <= mem[act_q][map_addr];
            ST_ROW_FIX:
                for (int c = 0; c < S; c++) mem[act_q][AW'(c * R + int'(row_q))] <= row_out[c];
            default: ;
        endcase
    end

    // outputs
    always_comb begin
        busy   = !open_q;
        done   = (state_q == ST_DONE);
        rd_key = (rd_addr < AW'(N)) ? mem[act_q][rd_addr] : '0;
    end

    assert_start_begins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (busy && pass_q == 4'd1));

    assert_busy_load_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_valid) |=> $stable(ld_ptr_q));

    assert_done_after_last_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(pass_q) == 4'd7));

    assert_perm_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PERMUTE) |-> (map_addr < AW'(N)));

    assert_pass_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (pass_q == $past(pass_q) || pass_q == $past(pass_q) + 4'd1));

    assert_pass_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pass_q >= 4'd1 && pass_q <= 4'd7));

endmodule

// File: tb/sim_colsort_engine.sv
module sim_colsort_engine;
    localparam int KW = 8;
    localparam int S  = 3;
    localparam int R  = S * S;
    localparam int N  = R * S;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0;
    logic [KW-1:0] load_key = '0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [AW-1:0] rd_addr = '0;
    logic [KW-1:0] rd_key;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [15:0] lf = 16'hACE1;
    logic [KW-1:0] cur [N];
    logic [KW-1:0] exp_s [N];

    always #4 clk = ~clk;

    colsort_engine #(.KEY_W(KW), .S(S)) u0 (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_key(load_key),
        .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_key(rd_key)
    );

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<=150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic load_all();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_key   = cur[k];
        end
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
        check(req, int'(done), 1);
        check(req, int'(busy), 0);
    endtask

    task automatic check_sorted(input string req);
        logic [KW-1:0] t;
        for (int k = 0; k < N; k++) exp_s[k] = cur[k];
        for (int a = 0; a < N - 1; a++)
            for (int b = 0; b < N - 1 - a; b++)
                if (exp_s[b] > exp_s[b+1]) begin
                    t = exp_s[b]; exp_s[b] = exp_s[b+1]; exp_s[b+1] = t;
                end
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            rd_addr = AW'(k);
            #1;
            check(req, int'(rd_key), int'(exp_s[k]));
        end
    endtask

    task automatic run_case(input string req);
        load_all();
        pulse_start();
        wait_done(req);
        check_sorted(req);
    endtask

    task automatic fill_lfsr();
        for (int k = 0; k < N; k++) begin
            lf = lf ^ (lf << 7);
            lf = lf ^ (lf >> 9);
            lf = lf ^ (lf << 8);
            cur[k] = lf[KW-1:0];
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 done after reset", int'(done), 0);
    endtask

    // R2: load order into column-major slots, readable before start
    task automatic t_readback();
        for (int k = 0; k < N; k++) cur[k] = KW'(3 * k + 1);
        load_all();
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            rd_addr = AW'(k);
            #1;
            check("R2 readback", int'(rd_key), 3 * k + 1);
        end
    endtask

    // R5 R6 R7 R8 R9: ordered patterns
    task automatic t_ascending();
        for (int k = 0; k < N; k++) cur[k] = KW'(k * 5);
        run_case("R5 R6 ascending");
    endtask

    task automatic t_descending();
        for (int k = 0; k < N; k++) cur[k] = KW'(250 - k * 7);
        run_case("R5 R7 descending");
    endtask

    // R6: duplicates must survive
    task automatic t_duplicates();
        for (int k = 0; k < N; k++) cur[k] = KW'((k * 11) % 3);
        run_case("R6 duplicates");
    endtask

    task automatic t_all_equal();
        for (int k = 0; k < N; k++) cur[k] = 8'd77;
        run_case("R6 all equal");
    endtask

    task automatic t_extremes();
        for (int k = 0; k < N; k++) cur[k] = (k % 2 == 0) ? 8'hFF : 8'h00;
        run_case("R9 extremes");
    endtask

    task automatic t_random();
        fill_lfsr();
        run_case("R8 random a");
        fill_lfsr();
        run_case("R9 random b");
    endtask

    // R3 R4: start and loads while busy are dropped
    task automatic t_busy_ignore();
        fill_lfsr();
        load_all();
        pulse_start();
        check("R3 busy after start", int'(busy), 1);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_key   = 8'h5A;
            start      = (c == 2);
        end
        @(negedge clk);
        load_valid = 1'b0;
        start      = 1'b0;
        check("R3 still busy", int'(busy), 1);
        wait_done("R4 busy ignore");
        check_sorted("R4 result unchanged");
    endtask

    // R10: load after done clears done and restarts at index 0
    task automatic t_reload();
        for (int k = 0; k < N; k++) cur[k] = KW'((k * 13 + 5) % 200);
        @(negedge clk);
        load_valid = 1'b1;
        load_key   = cur[0];
        @(negedge clk);
        check("R10 done cleared", int'(done), 0);
        check("R10 idle", int'(busy), 0);
        load_valid = 1'b0;
        rd_addr    = '0;
        #1;
        check("R10 index zero", int'(rd_key), int'(cur[0]));
        for (int k = 1; k < N; k++) begin
            @(negedge clk);
            load_valid = 1'b1;
            load_key   = cur[k];
        end
        @(negedge clk);
        load_valid = 1'b0;
        pulse_start();
        wait_done("R10 rerun");
        check_sorted("R10 rerun result");
    endtask

    initial begin
        t_reset();
        t_readback();
        pulse_start();
        wait_done("R5 first run");
        check_sorted("R5 first run result");
        t_ascending();
        t_descending();
        t_duplicates();
        t_all_equal();
        t_extremes();
        t_random();
        t_busy_ignore();
        t_reload();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule